// File: doc/BRIEF.md
# GPIO Event and Interrupt Detector

This block watches up to 32 general-purpose input lines and turns activity on them into sticky event flags and one combined interrupt request. The input word it receives has already been synchronised, polarity-adjusted and masked by the pin logic in front of it. The block only decides, per pin and per cycle, whether an event has happened. Each pin is configured independently. A mode bit chooses between level sensing and edge sensing. In edge mode, a second bit chooses rising edges only or both edges.

Detected events latch into a status word. Software clears that word by writing ones to the bits it has handled. A per-pin enable word selects which latched events may raise the interrupt. The enable word can be loaded whole, or changed through separate set and clear strobes, so one pin can be changed without a read-modify-write.

Edge detection compares the incoming word with a copy of it taken on the previous cycle. The interrupt line is registered, so it always lags the status and enable state by one cycle.

Top module: `gpio_evt_detect`

## Requirements
- R1: While reset is asserted, `evt_status`, `evt_enable` and `irq` are all zero.
- R2: A pin whose `evt_edge` bit is 0 is level-sensitive. If its `pin_in` bit is 1 at a clock edge, its `evt_status` bit is 1 after that edge.
- R3: For a pin whose `evt_edge` bit is 1, a 0-to-1 change of its `pin_in` bit (relative to the previous cycle) sets its status bit at that edge. This holds whatever its `evt_both` bit is.
- R4: For a pin whose `evt_edge` bit is 1, a 1-to-0 change sets its status bit only when its `evt_both` bit is 1. With `evt_both` 0, a falling input leaves the bit clear.
- R5: Status bits are sticky. A set bit falls only when `st_clr` is high and the matching `wr_data` bit is 1. A 0 in the clear mask leaves that bit unchanged. An edge-mode input held steady does not set the bit again.
- R6: When a clear of a bit and a new event for that bit occur in the same cycle, the event wins and the bit stays 1. A level-mode pin held high therefore cannot be cleared.
- R7: At a clock edge, `en_load` replaces `evt_enable` with `wr_data`. Otherwise `en_set` ORs `wr_data` into `evt_enable`. Otherwise `en_clr` clears the bits that are 1 in `wr_data`. The priority is load, then set, then clear.
- R8: `irq` is registered. It is 1 in the cycle after a cycle in which `evt_status & evt_enable` is nonzero, and 0 otherwise.
- R9: The previous-cycle copy of `pin_in` resets to zero. An edge-mode pin that is already 1 when reset is released therefore records a rising event at the first clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | N | Conditioned, synchronous input word |
| evt_edge | input | N | Per-pin mode: 0 level, 1 edge |
| evt_both | input | N | Per-pin edge choice: 0 rising only, 1 both edges |
| wr_data | input | N | Register bus write data for the strobes below |
| st_clr | input | 1 | Clear status bits that are 1 in `wr_data` |
| en_load | input | 1 | Load enable word from `wr_data` |
| en_set | input | 1 | Set enable bits that are 1 in `wr_data` |
| en_clr | input | 1 | Clear enable bits that are 1 in `wr_data` |
| evt_status | output | N | Sticky event status word |
| evt_enable | output | N | Interrupt enable word |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
The bench clears a level-mode bit while its input is still high. A design that let the clear win would drop the flag and lose a pending event. It checks a falling edge on two pins, one with the both-edge bit set and one without. A design that decoded the mode bits wrongly would flag the wrong pin or neither. It also holds an edge-mode input high after clearing, and issues a clear mask with zeros in it. A flag that re-fires in the first case, or one that falls in the second, would show a design that is not sticky. Finally, it releases reset with an edge-mode input already high, and checks the one-cycle lag of the interrupt behind both status and enable changes. These expose a previous-value copy reset to the wrong level and an interrupt path that is combinational instead of registered.

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_in,
  input  logic [N-1:0] evt_edge,
  input  logic [N-1:0] evt_both,
  input  logic [N-1:0] wr_data,
  input  logic         st_clr,
  input  logic         en_load,
  input  logic         en_set,
  input  logic         en_clr,
  output logic [N-1:0] evt_status,
  output logic [N-1:0] evt_enable,
  output logic         irq
);

  logic [N-1:0] prev_q;
  logic [N-1:0] rise, fall, hit, clr_mask;

  assign rise     = pin_in & ~prev_q;
  assign fall     = ~pin_in & prev_q;
  assign hit      = (~evt_edge & pin_in) | (evt_edge & rise) | (evt_edge & evt_both & fall);
  assign clr_mask = st_clr ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= '0;
      evt_status <= '0;
      irq        <= 1'b0;
    end else begin
      prev_q     <= pin_in;
      evt_status <= (evt_status & ~clr_mask) | hit;
      irq        <= |(evt_status & evt_enable);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       evt_enable <= '0;
    else if (en_load) evt_enable <= wr_data;
    else if (en_set)  evt_enable <= evt_enable | wr_data;
    else if (en_clr)  evt_enable <= evt_enable & ~wr_data;
  end

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_in & ~evt_edge) & ~evt_status) == '0)); // R2
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(pin_in & ~prev_q & evt_edge) & ~evt_status) == '0)); // R3
  AST_FALL_BOTH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~pin_in & prev_q & evt_edge & evt_both) & ~evt_status) == '0)); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_clr |=> ((evt_status & $past(evt_status)) == $past(evt_status))); // R5
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    st_clr |=> (($past(hit) & ~evt_status) == '0)); // R6
  AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_load && !en_set) |=> ((evt_enable & $past(wr_data)) == '0)); // R7
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(evt_status & evt_enable)))); // R8

endmodule

// File: tb/tb_gpio_evt_detect.sv
module tb_gpio_evt_detect;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0, evt_edge = '0, evt_both = '0, wr_data = '0;
  logic         st_clr = 1'b0, en_load = 1'b0, en_set = 1'b0, en_clr = 1'b0;
  logic [N-1:0] evt_status, evt_enable;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  gpio_evt_detect #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .evt_edge(evt_edge),
    .evt_both(evt_both), .wr_data(wr_data), .st_clr(st_clr),
    .en_load(en_load), .en_set(en_set), .en_clr(en_clr),
    .evt_status(evt_status), .evt_enable(evt_enable), .irq(irq)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_status(input logic [N-1:0] m);
    wr_data = m; st_clr = 1'b1;
    tick();
    st_clr = 1'b0; wr_data = '0;
  endtask

  task automatic quiesce();
    evt_edge = '1; evt_both = '0; pin_in = '0;
    tick();
    clear_status('1);
  endtask

  task automatic t_reset();
    tick(2);
    check("R1 status", evt_status, '0);
    check("R1 enable", evt_enable, '0);
    check("R1 irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_level();
    evt_edge = '0; evt_both = '0; pin_in = 32'h1;
    tick();
    check("R2 level sets", evt_status, 32'h1);
    pin_in = '0;
    tick(2);
    check("R5 sticky after input low", evt_status, 32'h1);
    clear_status(32'h2);
    check("R5 zero in clear mask", evt_status, 32'h1);
    clear_status(32'h1);
    check("R5 clear by one", evt_status, 32'h0);
    pin_in = 32'h1;
    tick();
    clear_status(32'h1);
    check("R6 level reasserts over clear", evt_status, 32'h1);
    quiesce();
    check("R5 cleanup", evt_status, '0);
  endtask

  task automatic t_edge();
    evt_edge = '1; evt_both = 32'h20; pin_in = 32'h30;
    tick();
    check("R3 rising any both-bit", evt_status, 32'h30);
    clear_status('1);
    tick(3);
    check("R5 held edge input no refire", evt_status, 32'h0);
    pin_in = '0;
    tick();
    check("R4 falling only with both-bit", evt_status, 32'h20);
    quiesce();
  endtask

  task automatic t_enable();
    wr_data = 32'hF0; en_load = 1'b1; tick(); en_load = 1'b0;
    check("R7 load", evt_enable, 32'hF0);
    wr_data = 32'h1; en_set = 1'b1; tick(); en_set = 1'b0;
    check("R7 set", evt_enable, 32'hF1);
    wr_data = 32'h10; en_clr = 1'b1; tick(); en_clr = 1'b0;
    check("R7 clear", evt_enable, 32'hE1);
    wr_data = 32'h3; en_load = 1'b1; en_set = 1'b1; tick();
    en_load = 1'b0; en_set = 1'b0;
    check("R7 load beats set", evt_enable, 32'h3);
    wr_data = '0; en_load = 1'b1; tick(); en_load = 1'b0;
    check("R7 load zero", evt_enable, 32'h0);
  endtask

  task automatic t_irq();
    evt_edge = '1; evt_both = '0; pin_in = 32'h100;
    tick();
    check("R3 bit8 rise", evt_status, 32'h100);
    tick();
    check("R8 no irq while disabled", {31'b0, irq}, '0);
    wr_data = 32'h100; en_set = 1'b1; tick(); en_set = 1'b0; wr_data = '0;
    check("R8 irq lags enable", {31'b0, irq}, '0);
    tick();
    check("R8 irq rises", {31'b0, irq}, 32'h1);
    clear_status(32'h100);
    check("R8 irq lags clear", {31'b0, irq}, 32'h1);
    tick();
    check("R8 irq falls", {31'b0, irq}, '0);
    wr_data = '0; en_load = 1'b1; tick(); en_load = 1'b0;
    quiesce();
  endtask

  task automatic t_prev_reset();
    evt_edge = '1; evt_both = '0; pin_in = 32'h80;
    rst_n = 1'b0;
    tick();
    check("R1 status in reset", evt_status, '0);
    rst_n = 1'b1;
    tick();
    check("R9 rise at reset release", evt_status, 32'h80);
    quiesce();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_enable();
    t_irq();
    t_prev_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule